// File: doc/BRIEF.md
# Synchronous SRAM burst address sequencer

This block sits in front of a pipelined synchronous burst SRAM array and decides, clock by clock, which word the array accesses. It captures a start address, then walks through a four-word burst. The upper address bits stay fixed. The two lowest bits follow either a linear order or an interleaved order.

The block has two active-low address strobes. One comes from a cache controller and loads unconditionally. The other comes from a processor and is honoured only while chip enable is low. When a load is accepted, the block also captures a registered "selected" flag from the three enable/select inputs. An active-low advance input steps the burst. When advance is high, the address holds. A static pin picks the burst order. All inputs are sampled on the rising clock edge, and a synchronous active-high reset clears the state.

Top module: `sram_burst_addr_seq`

## Requirements
- R1: When `strb_ctl_n` is low at a rising edge, `word_addr` equals the `addr_in` sampled at that edge from the next cycle on. This happens whatever the value of `en_n`.
- R2: When `strb_cpu_n` is low and `en_n` is low at a rising edge, `word_addr` takes the sampled `addr_in` in the same way as R1.
- R3: When `strb_cpu_n` is low while `en_n` is high, and `strb_ctl_n` is high, no load happens. With `adv_n` high, `word_addr` and `selected` stay unchanged.
- R4: On every accepted load, `selected` becomes 1 exactly when `en_n`=0, `sel_hi`=1 and `sel_lo_n`=0 at that edge, and 0 otherwise. `selected` holds its value on all cycles without a load.
- R5: With no load, `adv_n` high holds `word_addr` unchanged. With no load, `adv_n` low moves the burst one step.
- R6: With `order_ilv`=0 (linear order), the low two address bits are (start + steps) mod 4. Bits 17..2 keep the start value. Example: start low bits 1 gives 1,2,3,0.
- R7: With `order_ilv`=1 (interleaved order), the low two bits are start XOR steps, where steps counts 0,1,2,3. Examples: start 1 gives 1,0,3,2, and start 3 gives 3,2,1,0.
- R8: When a load and `adv_n`=0 occur at the same edge, the load wins. `word_addr` becomes the new start address and the step count restarts at 0.
- R9: When `rst` is high at a rising edge, `word_addr` becomes 0 and `selected` becomes 0.
- R10: After four advance steps, the burst wraps and `word_addr` returns to its start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 18 | Start word address |
| strb_cpu_n | input | 1 | Processor address strobe, active low, gated by `en_n` |
| strb_ctl_n | input | 1 | Cache-controller address strobe, active low, ungated |
| adv_n | input | 1 | Burst advance, active low |
| en_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| order_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| word_addr | output | 18 | Current word address |
| selected | output | 1 | Select state captured at the last load |

## Verification
The hardest situation to reach is a processor strobe that arrives while chip enable is high, in the middle of a burst whose state is already distinct from the strobe's address. Only then can an ignored strobe be told apart from a wrongly accepted one. The stimulus first loads a start address, steps the burst partway, and records the selected flag. It then raises `en_n` together with the processor strobe and a different address, and expects the address and the flag to stay frozen. A second hard corner is a load that coincides with an advance. It is reached by asserting both on the same edge in the middle of an interleaved burst.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } bsq_order_e;

  typedef struct packed {
    logic load;
    logic sel;
  } bsq_ctl_t;

endpackage

// File: rtl/bsq_load_qual.sv
module bsq_load_qual
  import bsq_pkg::*;
(
  input  logic     strb_cpu_n,
  input  logic     strb_ctl_n,
  input  logic     en_n,
  input  logic     sel_hi,
  input  logic     sel_lo_n,
  output bsq_ctl_t ctl
);

  logic cpu_ok;
  logic ctl_ok;

  always_comb begin
    ctl_ok   = ~strb_ctl_n;
    cpu_ok   = ~strb_cpu_n & ~en_n;
    ctl.load = ctl_ok | cpu_ok;
    ctl.sel  = ~en_n & sel_hi & ~sel_lo_n;
  end

endmodule

// File: rtl/bsq_burst_ctr.sv
module bsq_burst_ctr
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  bsq_ctl_t           ctl,
  input  logic               adv_n,
  input  logic [ADDR_W-1:0]  addr_in,
  output logic [ADDR_W-1:0]  base_q,
  output logic [BURST_W-1:0] step_q,
  output logic               sel_q
);

  localparam logic [BURST_W-1:0] STEP_ONE = BURST_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      step_q <= '0;
      sel_q  <= 1'b0;
    end else if (ctl.load) begin
      base_q <= addr_in;
      step_q <= '0;
      sel_q  <= ctl.sel;
    end else if (!adv_n) begin
      step_q <= step_q + STEP_ONE;
    end
  end

endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned BURST_W = 2
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [BURST_W-1:0] step,
  input  bsq_order_e         order,
  output logic [ADDR_W-1:0]  addr
);

  localparam int unsigned HI_W = ADDR_W - BURST_W;

  logic [BURST_W-1:0] low_lin;
  logic [BURST_W-1:0] low_ilv;
  logic [BURST_W-1:0] low_sel;

  always_comb begin
    low_lin = base[BURST_W-1:0] + step;
    low_ilv = base[BURST_W-1:0] ^ step;
    low_sel = (order == ORD_INTERLEAVE) ? low_ilv : low_lin;
  end

  generate
    if (HI_W > 0) begin : g_hi
      assign addr = {base[ADDR_W-1:BURST_W], low_sel};
    end else begin : g_nohi
      assign addr = low_sel;
    end
  endgenerate

endmodule

// File: rtl/sram_burst_addr_seq.sv
module sram_burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              en_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] word_addr,
  output logic              selected
);

  bsq_ctl_t           ctl;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] step_q;
  bsq_order_e         order;

  assign order = bsq_order_e'(order_ilv);

  bsq_load_qual u_qual (
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .en_n       (en_n),
    .sel_hi     (sel_hi),
    .sel_lo_n   (sel_lo_n),
    .ctl        (ctl)
  );

  bsq_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .adv_n   (adv_n),
    .addr_in (addr_in),
    .base_q  (base_q),
    .step_q  (step_q),
    .sel_q   (selected)
  );

  bsq_order_map #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_map (
    .base  (base_q),
    .step  (step_q),
    .order (order),
    .addr  (word_addr)
  );

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              adv_n,
  input logic              en_n,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic [ADDR_W-1:0] word_addr,
  input logic              selected
);

  logic ld;
  assign ld = !strb_ctl_n || (!strb_cpu_n && !en_n);

  assert_ctl_load_R1: assert property (@(posedge clk) disable iff (rst)
    !strb_ctl_n |=> word_addr == $past(addr_in));

  assert_cpu_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!strb_cpu_n && !en_n) |=> word_addr == $past(addr_in));

  assert_sel_capture_R4: assert property (@(posedge clk) disable iff (rst)
    ld |=> selected == $past(!en_n && sel_hi && !sel_lo_n));

  assert_hold_R5_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld && adv_n) |=> ($stable(word_addr) && $stable(selected)));

  assert_step_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv_n) |=> (word_addr[ADDR_W-1:BURST_W] == $past(word_addr[ADDR_W-1:BURST_W])
                         && word_addr != $past(word_addr) && $stable(selected)));

endmodule

bind sram_burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr_in    (addr_in),
  .strb_cpu_n (strb_cpu_n),
  .strb_ctl_n (strb_ctl_n),
  .adv_n      (adv_n),
  .en_n       (en_n),
  .sel_hi     (sel_hi),
  .sel_lo_n   (sel_lo_n),
  .word_addr  (word_addr),
  .selected   (selected)
);

// File: tb/sram_burst_addr_seq_bench.sv
`timescale 1ns/1ps
module sram_burst_addr_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] addr_in = '0;
  logic        strb_cpu_n = 1'b1;
  logic        strb_ctl_n = 1'b1;
  logic        adv_n = 1'b1;
  logic        en_n = 1'b1;
  logic        sel_hi = 1'b0;
  logic        sel_lo_n = 1'b1;
  logic        order_ilv = 1'b0;
  logic [17:0] word_addr;
  logic        selected;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [18:0] exp_q[$];
  string       tag_q[$];

  logic [17:0] m_base = '0;
  logic [1:0]  m_step = '0;
  logic        m_sel = 1'b0;

  always #10 clk = ~clk;

  sram_burst_addr_seq u_sram_burst_addr_seq (
    .clk(clk), .rst(rst), .addr_in(addr_in), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .en_n(en_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .order_ilv(order_ilv), .word_addr(word_addr),
    .selected(selected)
  );

  function automatic logic [17:0] model_addr();
    logic [1:0] lo;
    lo = order_ilv ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step);
    return {m_base[17:2], lo};
  endfunction

  // Driver: applies one cycle of stimulus and queues what must appear after the edge.
  task automatic step(input logic r, input logic [17:0] a, input logic ctl_n,
                      input logic cpu_n, input logic av_n, input logic e_n,
                      input logic s_hi, input logic s_lo_n, input string tag);
    @(negedge clk);
    rst = r; addr_in = a; strb_ctl_n = ctl_n; strb_cpu_n = cpu_n;
    adv_n = av_n; en_n = e_n; sel_hi = s_hi; sel_lo_n = s_lo_n;
    if (r) begin
      m_base = '0; m_step = '0; m_sel = 1'b0;
    end else if (!ctl_n || (!cpu_n && !e_n)) begin
      m_base = a; m_step = '0; m_sel = !e_n && s_hi && !s_lo_n;
    end else if (!av_n) begin
      m_step = m_step + 2'd1;
    end
    exp_q.push_back({model_addr(), m_sel});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 18'h3FFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, tag);
  endtask

  task automatic adv(input string tag);
    step(1'b0, 18'h00000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, tag);
  endtask

  // Monitor: compares the design against the queue after every edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [18:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if ({word_addr, selected} !== e) begin
          bad++;
          $display("FAIL %s: actual addr=%05h sel=%0b expected addr=%05h sel=%0b",
                   t, word_addr, selected, e[18:1], e[0]);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step(1'b1, 18'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R9 reset state");
    // Controller strobe loads with chip disabled; linear burst from low bits 01
    step(1'b0, 18'h12345, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R1 ctl load en_n high, R4 sel=0");
    for (int i = 0; i < 4; i++) adv("R6 linear step / R10 wrap");
    idle("R5 hold");
    // Processor strobe with chip enabled and selected; start low bits 10
    step(1'b0, 18'h2ABCE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2 cpu load, R4 sel=1");
    idle("R5 hold");
    adv("R6 linear 10->11");
    idle("R5 hold mid-burst");
    // Ignored processor strobe with chip enable high, mid-burst
    step(1'b0, 18'h01111, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R3 cpu strobe ignored");
    step(1'b0, 18'h02222, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 ignored strobe, advance only");
    for (int i = 0; i < 2; i++) adv("R6 linear / R10 wrap");
    // Deselect on a load with the low-active select high
    step(1'b0, 18'h3C001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4 load sel=0");
    order_ilv = 1'b1;
    for (int i = 0; i < 4; i++) adv("R7 interleaved from 01 / R10 wrap");
    step(1'b0, 18'h15557, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R1 ctl load sel=1");
    for (int i = 0; i < 2; i++) adv("R7 interleaved from 11");
    // Load and advance together: load wins
    step(1'b0, 18'h0ABC2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8 load beats advance");
    adv("R8 step count restarted, R7");
    step(1'b0, 18'h30004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 cpu load beats advance");
    adv("R7 interleaved from 00");
    for (int i = 0; i < 2; i++) adv("R7 interleaved / R4 sel held");
    step(1'b1, 18'h3FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 reset mid-burst");
    idle("R9 held after reset");
    repeat (3) @(posedge clk);
    #5;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule